// File: doc/BRIEF.md
# Re-execute Decision Flag Queue

This block sits between the commit stage of a leading (main) thread and the decode stage of a trailing (redundant) thread. Every main-thread instruction that commits leaves behind one flag: 1 when its result did not match the value expected for it, and 0 when it did. The trailing thread reads these flags back in the same program order. A trailing instruction with flag 1 is sent on to execute again. A trailing instruction with flag 0 is fetched but skipped.

The flags sit in a circular queue of single bits. The queue holds `SLACK + MARGIN` entries, where `MARGIN` is at least 1, so its depth is always greater than the lag between the threads. When the queue is full, the commit side is held back. When it is empty, the decode side is held back. A store carries two checks, one on its address and one on its data, and these are merged into one flag. Occupancy is tracked by a three-state machine with states EMPTY, PARTIAL and FULL:

- EMPTY to PARTIAL on an accepted push.
- PARTIAL to FULL on a push without a pop when one slot is left.
- PARTIAL to EMPTY on a pop without a push when one flag is left.
- FULL to PARTIAL on a pop.
- Any state to EMPTY on flush.

In every other case the state holds.

Top module: `reexec_flag_fifo`

## Requirements
- R1: After reset, `decode_stall` is 1 and `commit_stall` is 0.
- R2: For a non-store commit (`commit_store`=0), the flag pushed equals `commit_fail_main`, and `commit_fail_data` is ignored.
- R3: For a store commit (`commit_store`=1), the flag pushed is 1 when `commit_fail_main` or `commit_fail_data` is 1, and 0 only when both are 0.
- R4: Flags leave in the same order they were pushed, one per accepted pop.
- R5: `commit_stall` is 1 exactly when `DEPTH` = `SLACK`+`MARGIN` flags are held. A push while full is dropped and stores nothing.
- R6: `decode_stall` is 1 exactly when no flag is held. A pop while empty has no effect.
- R7: A push and a pop in the same cycle are both performed when the queue is neither empty nor full, and the occupancy stays unchanged.
- R8: `flush` empties the queue in the next cycle and takes priority over a push or pop in the same cycle.
- R9: While `decode_stall` is 0, `reexec` shows the oldest held flag. 1 means the instruction must be re-executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the queue |
| commit_valid | input | 1 | A main-thread instruction commits this cycle |
| commit_store | input | 1 | The committing instruction is a store |
| commit_fail_main | input | 1 | Result or address check failed |
| commit_fail_data | input | 1 | Store data check failed |
| commit_stall | output | 1 | Queue full, so commit must wait |
| decode_req | input | 1 | A trailing instruction takes a flag this cycle |
| decode_stall | output | 1 | Queue empty, so decode must wait |
| reexec | output | 1 | Oldest flag: 1 means execute again |

## Verification
The two functions that can fall in the same cycle are a commit-side push and a decode-side pop. Each also competes with flush.

The bench provokes overlapping pushes and pops in three situations:
- at partial fill, where both must take effect;
- at full, where only the pop may take effect;
- at empty, where only the push may take effect.

It also raises flush together with both a push and a pop. A behavioural queue model decides, after every edge, what the stalls and the head flag must show, and the design is compared against it each cycle.

// File: rtl/reexec_fifo_pkg.sv
package reexec_fifo_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

endpackage

// File: rtl/reexec_flag_merge.sv
module reexec_flag_merge (
    input  logic commit_store,
    input  logic fail_main,
    input  logic fail_data,
    output logic flag
);

    // R2 / R3: the data check only counts for stores
    always_comb begin
        if (commit_store) begin
            flag = fail_main | fail_data;
        end else begin
            flag = fail_main;
        end
    end

endmodule

// File: rtl/reexec_occ_fsm.sv
module reexec_occ_fsm
    import reexec_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] LAST_FREE = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    occ_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = OCC_EMPTY;
        end else begin
            unique case (state_q)
                OCC_EMPTY: begin
                    if (push) state_d = OCC_PARTIAL;
                end
                OCC_PARTIAL: begin
                    if (push && !pop && cnt_q == LAST_FREE) begin
                        state_d = OCC_FULL;
                    end else if (pop && !push && cnt_q == ONE) begin
                        state_d = OCC_EMPTY;
                    end
                end
                OCC_FULL: begin
                    if (pop) state_d = OCC_PARTIAL;
                end
                default: state_d = OCC_EMPTY;
            endcase
        end
    end

    always_comb begin
        cnt_d = cnt_q;
        if (flush) begin
            cnt_d = '0;
        end else if (push && !pop) begin
            cnt_d = cnt_q + ONE;
        end else if (pop && !push) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        full  = 1'b0;
        empty = 1'b0;
        unique case (state_q)
            OCC_EMPTY:   empty = 1'b1;
            OCC_PARTIAL: ;
            OCC_FULL:    full  = 1'b1;
            default:     empty = 1'b1;
        endcase
    end

    assign count = cnt_q;

endmodule

// File: rtl/reexec_flag_store.sv
module reexec_flag_store #(
    parameter int DEPTH = 16,
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic push,
    input  logic pop,
    input  logic flag_in,
    output logic flag_out
);

    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [DEPTH-1:0] bits_q;
    logic [PTR_W-1:0] wr_q, rd_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else if (flush) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (push) wr_q <= bump(wr_q);
            if (pop)  rd_q <= bump(rd_q);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits_q[i] <= 1'b0;
            end else if (!flush && push && wr_q == PTR_W'(i)) begin
                bits_q[i] <= flag_in;
            end
        end
    end

    assign flag_out = bits_q[rd_q];

endmodule

// File: rtl/reexec_flag_fifo.sv
module reexec_flag_fifo #(
    parameter int SLACK  = 12,
    parameter int MARGIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic commit_valid,
    input  logic commit_store,
    input  logic commit_fail_main,
    input  logic commit_fail_data,
    output logic commit_stall,
    input  logic decode_req,
    output logic decode_stall,
    output logic reexec
);

    // depth always exceeds the inter-thread slack
    localparam int DEPTH = SLACK + ((MARGIN < 1) ? 1 : MARGIN);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             full, empty;
    logic             push_go, pop_go;
    logic             new_flag;
    logic [CNT_W-1:0] occ_count;

    assign push_go = commit_valid && !full;
    assign pop_go  = decode_req && !empty;

    reexec_flag_merge merge_i (
        .commit_store (commit_store),
        .fail_main    (commit_fail_main),
        .fail_data    (commit_fail_data),
        .flag         (new_flag)
    );

    reexec_occ_fsm #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) occ_i (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push_go),
        .pop   (pop_go),
        .full  (full),
        .empty (empty),
        .count (occ_count)
    );

    reexec_flag_store #(
        .DEPTH (DEPTH)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push     (push_go),
        .pop      (pop_go),
        .flag_in  (new_flag),
        .flag_out (reexec)
    );

    assign commit_stall = full;
    assign decode_stall = empty;

endmodule

// File: rtl/reexec_flag_fifo_chk.sv
module reexec_flag_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             push,
    input logic             pop,
    input logic             commit_stall,
    input logic             decode_stall,
    input logic             reexec,
    input logic [CNT_W-1:0] count
);

    p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (decode_stall && !commit_stall && count == '0));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stall |-> (count == CNT_W'(DEPTH)));

    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        decode_stall |-> (count == '0));

    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    p_both_ops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !flush) |=> (count == $past(count)));

    p_head_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!decode_stall && !pop && !flush) |=> $stable(reexec));

    p_empty_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && count == CNT_W'(1)) |=> decode_stall);

endmodule

bind reexec_flag_fifo reexec_flag_fifo_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .push         (push_go),
    .pop          (pop_go),
    .commit_stall (commit_stall),
    .decode_stall (decode_stall),
    .reexec       (reexec),
    .count        (occ_count)
);

// File: tb/reexec_flag_fifo_tb_top.sv
module reexec_flag_fifo_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SLACK      = 12;
    localparam int MARGIN     = 4;
    localparam int DEPTH      = SLACK + MARGIN;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic commit_valid = 1'b0;
    logic commit_store = 1'b0;
    logic commit_fail_main = 1'b0;
    logic commit_fail_data = 1'b0;
    logic decode_req = 1'b0;
    logic commit_stall, decode_stall, reexec;

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";
    bit    model_q[$];
    bit    done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    reexec_flag_fifo #(
        .SLACK  (SLACK),
        .MARGIN (MARGIN)
    ) dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .flush            (flush),
        .commit_valid     (commit_valid),
        .commit_store     (commit_store),
        .commit_fail_main (commit_fail_main),
        .commit_fail_data (commit_fail_data),
        .commit_stall     (commit_stall),
        .decode_req       (decode_req),
        .decode_stall     (decode_stall),
        .reexec           (reexec)
    );

    task automatic check_bit(input string req, input string what,
                             input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t",
                     req, what, act, exp, $time);
        end
    endtask

    // compare outputs against the model, away from the clock edge
    task automatic compare();
        int sz = model_q.size();
        check_bit((sz == DEPTH) ? "R5" : tag, "commit_stall",
                  commit_stall, (sz == DEPTH));
        check_bit((sz == 0) ? "R6" : tag, "decode_stall",
                  decode_stall, (sz == 0));
        if (sz > 0) check_bit(tag, "reexec (R9)", reexec, model_q[0]);
    endtask

    task automatic step(input bit cv, input bit st, input bit fm,
                        input bit fd, input bit dr, input bit fl);
        bit flag;
        bit push_ok;
        bit pop_ok;
        @(negedge clk);
        compare();
        commit_valid     = cv;
        commit_store     = st;
        commit_fail_main = fm;
        commit_fail_data = fd;
        decode_req       = dr;
        flush            = fl;
        @(posedge clk);
        flag    = st ? (fm | fd) : fm;
        push_ok = cv && (model_q.size() < DEPTH);
        pop_ok  = dr && (model_q.size() > 0);
        if (fl) begin
            model_q.delete();
        end else begin
            if (pop_ok)  void'(model_q.pop_front());
            if (push_ok) model_q.push_back(flag);
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: state right after reset
        tag = "R1";
        step(0, 0, 0, 0, 0, 0);

        // R2: non-store, data check must be ignored
        tag = "R2";
        for (int i = 0; i < 6; i++) step(1, 0, i[0], ~i[0], 0, 0);
        for (int i = 0; i < 7; i++) step(0, 0, 0, 0, 1, 0);

        // R3: store merges both checks
        tag = "R3";
        for (int i = 0; i < 4; i++) step(1, 1, i[1], i[0], 0, 0);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, 0);

        // R5: fill past capacity, pushes while full are dropped
        tag = "R5";
        for (int i = 0; i < DEPTH + 3; i++) step(1, 0, (i % 3 == 0), 0, 0, 0);
        // full with push and pop together: only the pop happens
        step(1, 0, 1, 0, 1, 0);
        step(0, 0, 0, 0, 0, 0);

        // R6: drain past empty, pops while empty do nothing
        tag = "R6";
        for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 0, 1, 0);
        // empty with push and pop together: only the push happens
        step(1, 0, 1, 0, 1, 0);
        step(0, 0, 0, 0, 0, 0);

        // R7: simultaneous push and pop at partial fill
        tag = "R7";
        for (int i = 0; i < 5; i++) step(1, 1, 0, i[0], 0, 0);
        for (int i = 0; i < 20; i++) step(1, i[1], i[0], i[2], 1, 0);

        // R8: flush wins over push and pop in the same cycle
        tag = "R8";
        step(1, 0, 1, 0, 1, 1);
        step(0, 0, 0, 0, 0, 0);
        step(1, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);

        // R4: ordering under mixed traffic
        tag = "R4";
        for (int i = 0; i < 2000; i++) begin
            int r = $urandom_range(0, 99);
            step(r < 60, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 1) == 1, $urandom_range(0, 99) < 50,
                 r == 99);
        end
        step(0, 0, 0, 0, 0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule